// File: doc/BRIEF.md
# Clock Source Switching Sequencer

This block moves the system clock between three sources: an on-chip oscillator, an external crystal and an external RC network. The RC network draws its supply from a general-purpose pin, so the pin has to be released before the crystal starts and driven again once the crystal has stopped. A request names a target source. The sequencer always parks the clock on the on-chip oscillator first. It then steps through the drive-enable and pin controls in a fixed order, one action per cycle, and selects the external source only when that source is ready.

The crystal path waits a fixed startup window. The window is counted in on-chip oscillator cycles and its length is a parameter. After the window, the sequencer waits for a crystal-valid input, bounded by a programmable timeout. If the timeout expires, the crystal drive is switched off, the clock stays on the on-chip oscillator and an error flag is set. A busy flag covers each sequence, and a single-cycle done pulse ends it. The request also carries an on-chip oscillator frequency code, which is applied when the request is accepted.

Top module: `clk_src_seq`

## Requirements
- R1: After reset, clk_sel is 0 (on-chip), xtal_en is 0, rc_pin_pushpull is 0, rc_pin_latch is 1, busy, done and err are 0, and int_freq is 0.
- R2: A req_valid seen while idle is accepted on that edge. From the next cycle, busy is 1 and clk_sel is 0 whenever the target differs from the current source. Source codes: 0 = on-chip, 1 = crystal, 2 = RC, and 3 is treated as 0.
- R3: On a change to the crystal, one cycle after the on-chip oscillator is selected, rc_pin_pushpull goes to 0, rc_pin_latch goes to 1 and xtal_en goes to 1, all in the same cycle. The crystal drive stays on if the clock later returns to the on-chip oscillator.
- R4: When crystal-valid is already high, clk_sel becomes 1 exactly STARTUP_CYCLES+1 cycles after xtal_en rises, and never earlier.
- R5: After the startup window, clk_sel becomes 1 only on the cycle after xtal_ok is sampled high.
- R6: If xtal_ok stays low, xtal_en falls STARTUP_CYCLES+1+tmo_limit cycles after it rose. At that point err becomes 1 and clk_sel stays 0.
- R7: On a change from the crystal to RC, these happen one per cycle in this order: clk_sel goes to 0, xtal_en goes to 0, rc_pin_pushpull goes to 1 with rc_pin_latch at 1, and clk_sel goes to 2.
- R8: At the end of a sequence, busy falls and done is high for exactly one cycle on the same edge.
- R9: A request that arrives while busy is 1 is ignored: the running sequence finishes at its own target.
- R10: A request for the source already selected changes no select or pin output. busy is high for one cycle and then done pulses.
- R11: clk_sel never moves directly between 1 and 2. Every output change follows a sequence step.
- R12: int_freq takes the value of req_freq (0 = 2 MHz, 1 = 4, 2 = 8, 3 = 16) when a request is accepted, and then holds it.
- R13: err is cleared when the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | on-chip oscillator clock |
| rst_n | input | 1 | synchronous active-low reset |
| req_valid | input | 1 | request strobe |
| req_src | input | 2 | target source code |
| req_freq | input | 2 | on-chip frequency code |
| tmo_limit | input | TMO_W | extra cycles allowed for crystal-valid |
| xtal_ok | input | 1 | crystal running and stable |
| clk_sel | output | 2 | system clock source select |
| int_freq | output | 2 | applied on-chip frequency code |
| xtal_en | output | 1 | crystal drive enable |
| rc_pin_pushpull | output | 1 | RC supply pin output mode (1 = push-pull) |
| rc_pin_latch | output | 1 | RC supply pin latch value |
| busy | output | 1 | sequence in progress |
| done | output | 1 | single-cycle completion pulse |
| err | output | 1 | crystal-valid timeout occurred |

## Verification
The assertions assume that xtal_ok changes only in step with clk and that tmo_limit does not change while the sequencer waits for crystal-valid. The bench drives all inputs on the falling edge and changes tmo_limit only while the block is idle. The bench also assumes that req_valid may arrive at any time, including during a sequence, and it deliberately issues one request in the middle of the startup window.

// File: rtl/clk_seq_pkg.sv
// Shared source codes and sequencer states for the clock source switcher.
package clk_seq_pkg;
    typedef enum logic [1:0] {
        SRC_INT  = 2'd0,
        SRC_XTAL = 2'd1,
        SRC_RC   = 2'd2
    } src_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_XON,
        ST_DLY,
        ST_VLD,
        ST_XOFF,
        ST_RCON,
        ST_SELRC,
        ST_FIN
    } st_t;
endpackage

// File: rtl/clk_seq_count.sv
// Window counter. It counts while run is high and holds at limit, where hit
// is raised. It clears whenever run is low.
// Assumes limit is stable while run is high.
module clk_seq_count #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic [W-1:0] limit,
    output logic         hit
);
    logic [W-1:0] count;

    // terminal-count compare
    assign hit = run && (count == limit);

    // advance while running, clear while idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (!run) begin
            count <= '0;
        end else if (!hit) begin
            count <= count + 1'b1;
        end
    end

    // R6
    count_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run && $past(run) && $past(!hit) |-> count == $past(count) + 1'b1);
endmodule

// File: rtl/clk_seq_fsm.sv
// Step sequencer. It performs one clock-select or pin/drive action per state,
// always passing through the on-chip oscillator.
// Assumes xtal_ok is synchronous to clk.
module clk_seq_fsm
    import clk_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic [1:0] req_src,
    input  logic [1:0] req_freq,
    input  logic       xtal_ok,
    input  logic       dly_hit,
    input  logic       tmo_hit,
    output logic       dly_run,
    output logic       tmo_run,
    output logic [1:0] clk_sel,
    output logic [1:0] int_freq,
    output logic       xtal_en,
    output logic       pin_pp,
    output logic       pin_latch,
    output logic       busy,
    output logic       done,
    output logic       err
);
    st_t  state;
    src_t tgt;

    // decode request target; the unused code maps to on-chip
    always_comb begin
        case (req_src)
            2'd1:    tgt = SRC_XTAL;
            2'd2:    tgt = SRC_RC;
            default: tgt = SRC_INT;
        endcase
    end

    // window counters run only in their waiting states
    assign dly_run = (state == ST_DLY);
    assign tmo_run = (state == ST_VLD);

    // sequence steps and registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            clk_sel   <= SRC_INT;
            int_freq  <= 2'd0;
            xtal_en   <= 1'b0;
            pin_pp    <= 1'b0;
            pin_latch <= 1'b1;
            busy      <= 1'b0;
            done      <= 1'b0;
            err       <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        busy     <= 1'b1;
                        err      <= 1'b0;
                        int_freq <= req_freq;
                        if (tgt == src_t'(clk_sel)) begin
                            state <= ST_FIN;
                        end else begin
                            clk_sel <= SRC_INT;
                            case (tgt)
                                SRC_XTAL: state <= ST_XON;
                                SRC_RC:   state <= ST_XOFF;
                                default:  state <= ST_FIN;
                            endcase
                        end
                    end
                end
                ST_XON: begin
                    pin_pp    <= 1'b0;
                    pin_latch <= 1'b1;
                    xtal_en   <= 1'b1;
                    state     <= ST_DLY;
                end
                ST_DLY: begin
                    if (dly_hit) state <= ST_VLD;
                end
                ST_VLD: begin
                    if (xtal_ok) begin
                        clk_sel <= SRC_XTAL;
                        state   <= ST_FIN;
                    end else if (tmo_hit) begin
                        xtal_en <= 1'b0;
                        err     <= 1'b1;
                        state   <= ST_FIN;
                    end
                end
                ST_XOFF: begin
                    xtal_en <= 1'b0;
                    state   <= ST_RCON;
                end
                ST_RCON: begin
                    pin_pp    <= 1'b1;
                    pin_latch <= 1'b1;
                    state     <= ST_SELRC;
                end
                ST_SELRC: begin
                    clk_sel <= SRC_RC;
                    state   <= ST_FIN;
                end
                ST_FIN: begin
                    busy  <= 1'b0;
                    done  <= 1'b1;
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R11
    no_ext_to_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_sel != $past(clk_sel)) && ($past(clk_sel) != SRC_INT) |-> clk_sel == SRC_INT);

    // R5
    xtal_sel_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_sel == SRC_XTAL) && ($past(clk_sel) != SRC_XTAL) |-> $past(xtal_ok) && xtal_en && !pin_pp);

    // R7
    rc_sel_needs_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_sel == SRC_RC) |-> pin_pp && pin_latch && !xtal_en);

    // R3
    pin_hiz_with_xtal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xtal_en |-> !pin_pp && pin_latch);

    // R8
    done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy) && !busy);

    // R6
    abort_keeps_int_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> !xtal_en && clk_sel == SRC_INT);

    // R9
    freq_held_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(busy) && busy |-> $stable(int_freq));
endmodule

// File: rtl/clk_src_seq.sv
// Clock source switching sequencer top. It ties the step sequencer to a
// fixed startup-window counter and a programmable valid-timeout counter.
// Assumes clk is the on-chip oscillator and STARTUP_CYCLES >= 2.
module clk_src_seq
    import clk_seq_pkg::*;
#(
    parameter int STARTUP_CYCLES = 16000,
    parameter int TMO_W          = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [1:0]       req_src,
    input  logic [1:0]       req_freq,
    input  logic [TMO_W-1:0] tmo_limit,
    input  logic             xtal_ok,
    output logic [1:0]       clk_sel,
    output logic [1:0]       int_freq,
    output logic             xtal_en,
    output logic             rc_pin_pushpull,
    output logic             rc_pin_latch,
    output logic             busy,
    output logic             done,
    output logic             err
);
    localparam int DLY_W = $clog2(STARTUP_CYCLES);
    localparam logic [DLY_W-1:0] DLY_LAST = DLY_W'(STARTUP_CYCLES - 1);

    logic dly_run, dly_hit, tmo_run, tmo_hit;

    clk_seq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_src   (req_src),
        .req_freq  (req_freq),
        .xtal_ok   (xtal_ok),
        .dly_hit   (dly_hit),
        .tmo_hit   (tmo_hit),
        .dly_run   (dly_run),
        .tmo_run   (tmo_run),
        .clk_sel   (clk_sel),
        .int_freq  (int_freq),
        .xtal_en   (xtal_en),
        .pin_pp    (rc_pin_pushpull),
        .pin_latch (rc_pin_latch),
        .busy      (busy),
        .done      (done),
        .err       (err)
    );

    clk_seq_count #(.W(DLY_W)) u_dly (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (dly_run),
        .limit (DLY_LAST),
        .hit   (dly_hit)
    );

    clk_seq_count #(.W(TMO_W)) u_tmo (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (tmo_run),
        .limit (tmo_limit),
        .hit   (tmo_hit)
    );
endmodule

// File: tb/clk_src_seq_test.sv
`timescale 1ns/1ps
module clk_src_seq_test;
    localparam int N = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [1:0] req_src = 2'd0;
    logic [1:0] req_freq = 2'd0;
    logic [15:0] tmo_limit = 16'd5;
    logic       xtal_ok = 1'b1;
    logic [1:0] clk_sel, int_freq;
    logic       xtal_en, rc_pin_pushpull, rc_pin_latch, busy, done, err;

    always #2 clk = ~clk;

    clk_src_seq #(.STARTUP_CYCLES(N), .TMO_W(16)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_src(req_src),
        .req_freq(req_freq), .tmo_limit(tmo_limit), .xtal_ok(xtal_ok),
        .clk_sel(clk_sel), .int_freq(int_freq), .xtal_en(xtal_en),
        .rc_pin_pushpull(rc_pin_pushpull), .rc_pin_latch(rc_pin_latch),
        .busy(busy), .done(done), .err(err)
    );

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int t_xon = 0, t_xoff = 0, t_sel = 0;
    bit mon_on = 1'b0;
    bit ended = 1'b0;
    logic [4:0] exp_q[$];
    string      tag_q[$];
    logic [4:0] prev = '0;
    logic [4:0] cur;
    logic [4:0] e;
    string      t;

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic expect_snap(string tag, logic [1:0] cs, logic xe, logic pp, logic la);
        exp_q.push_back({cs, xe, pp, la});
        tag_q.push_back(tag);
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    // monitor: pops expected output snapshots on every change
    always @(negedge clk) begin
        cyc++;
        cur = {clk_sel, xtal_en, rc_pin_pushpull, rc_pin_latch};
        if (mon_on && cur !== prev) begin
            if (exp_q.size() == 0) begin
                chk("R11 unexpected output change", int'(cur), int'(prev));
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(t, int'(cur), int'(e));
            end
            if (cur[2] && !prev[2]) t_xon = cyc;
            if (!cur[2] && prev[2]) t_xoff = cyc;
            if (cur[4:3] == 2'd1 && prev[4:3] != 2'd1) t_sel = cyc;
        end
        prev = cur;
    end

    task automatic request(logic [1:0] src, logic [1:0] fr);
        @(negedge clk);
        req_valid = 1'b1;
        req_src   = src;
        req_freq  = fr;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_done();
        @(negedge clk);
        while (!done) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1 reset values, sampled while reset is held
        chk("R1 clk_sel", clk_sel, 0);
        chk("R1 xtal_en", xtal_en, 0);
        chk("R1 pushpull", rc_pin_pushpull, 0);
        chk("R1 latch", rc_pin_latch, 1);
        chk("R1 busy/done/err", {busy, done, err}, 0);
        chk("R1 int_freq", int_freq, 0);
        rst_n = 1'b1;
        @(posedge clk);
        #1 mon_on = 1'b1;

        // crystal with valid already high, plus an ignored request
        expect_snap("R3 crystal drive on, pin released", 2'd0, 1'b1, 1'b0, 1'b1);
        expect_snap("R4 crystal selected", 2'd1, 1'b1, 1'b0, 1'b1);
        request(2'd1, 2'd2);
        chk("R2 busy after accept", busy, 1);
        chk("R2 on-chip selected", clk_sel, 0);
        repeat (5) @(negedge clk);
        request(2'd2, 2'd1);
        wait_done();
        chk("R8 busy low with done", busy, 0);
        chk("R4 startup delay", t_sel - t_xon, N + 1);
        chk("R9 target kept crystal", clk_sel, 1);
        chk("R9 pin untouched", rc_pin_pushpull, 0);
        chk("R12 frequency code captured", int_freq, 2);
        @(negedge clk);
        chk("R8 done one cycle", done, 0);

        // crystal to RC
        expect_snap("R7 step1 on-chip", 2'd0, 1'b1, 1'b0, 1'b1);
        expect_snap("R7 step2 crystal off", 2'd0, 1'b0, 1'b0, 1'b1);
        expect_snap("R7 step3 pin driven", 2'd0, 1'b0, 1'b1, 1'b1);
        expect_snap("R7 step4 RC selected", 2'd2, 1'b0, 1'b1, 1'b1);
        request(2'd2, 2'd2);
        wait_done();
        chk("R7 final select", clk_sel, 2);

        // same-source request
        request(2'd2, 2'd2);
        chk("R10 busy one cycle", busy, 1);
        @(negedge clk);
        chk("R10 done pulse", done, 1);
        chk("R10 busy cleared", busy, 0);
        chk("R10 still RC", clk_sel, 2);

        // crystal timeout
        xtal_ok = 1'b0;
        tmo_limit = 16'd5;
        expect_snap("R2 on-chip from RC", 2'd0, 1'b0, 1'b1, 1'b1);
        expect_snap("R3 pin released with drive", 2'd0, 1'b1, 1'b0, 1'b1);
        expect_snap("R6 drive dropped on timeout", 2'd0, 1'b0, 1'b0, 1'b1);
        request(2'd1, 2'd0);
        wait_done();
        chk("R6 err set", err, 1);
        chk("R6 on-chip kept", clk_sel, 0);
        chk("R6 timeout window", t_xoff - t_xon, N + 1 + 5);

        // late valid
        tmo_limit = 16'd50;
        expect_snap("R3 drive on again", 2'd0, 1'b1, 1'b0, 1'b1);
        expect_snap("R5 crystal after valid", 2'd1, 1'b1, 1'b0, 1'b1);
        request(2'd1, 2'd1);
        chk("R13 err cleared on accept", err, 0);
        while (!xtal_en) @(negedge clk);
        repeat (30) @(negedge clk);
        chk("R5 not selected without valid", clk_sel, 0);
        xtal_ok = 1'b1;
        @(negedge clk);
        chk("R5 selected after valid", clk_sel, 1);
        wait_done();
        chk("R13 err stays clear", err, 0);

        // back to on-chip with a new frequency
        expect_snap("R2 on-chip from crystal", 2'd0, 1'b1, 1'b0, 1'b1);
        request(2'd0, 2'd3);
        wait_done();
        chk("R12 frequency 16 MHz code", int_freq, 3);
        chk("R3 crystal left running", xtal_en, 1);
        repeat (3) @(negedge clk);
        chk("R11 all expected changes seen", exp_q.size(), 0);
        finish_run();
    end
endmodule